// File: doc/BRIEF.md
# Receive Frame Ones-Complement Sum Accumulator

This block watches a received frame arrive one byte per cycle and builds a raw 16-bit ones-complement sum of it. The descriptor writeback logic stores that sum for the frame. Summing begins at a byte offset set by configuration and measured from the first byte of the frame. An offset of zero starts the sum at the first byte of the destination address. From that point the sum runs to the final byte of the frame, so the link-layer header, the IP header and the trailing CRC are all included. The block makes no pseudo-header correction and does not judge whether the sum is correct. Software uses the raw value to work out any protocol checksum it needs.

Counting from the start offset, bytes pair into big-endian 16-bit words. Every carry out of bit 15 is added back into the sum. If the summed region has an odd number of bytes, the last byte is taken as the high half of a word whose low half is zero. One cycle after the end-of-frame byte is accepted, the block presents one result per frame together with a single-cycle done strobe. The result then holds until the next frame completes.

Top module: `rx_ocsum`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `csum_out` is 0 and `csum_done` is low.
- R2: Bytes pair into words counted from the start offset: the byte at an even distance from the offset is the high byte (bits 15:8) and the following byte is the low byte (bits 7:0).
- R3: Each word is added with end-around carry: a carry out of bit 15 is added back into bit 0. For example, the words FFFF, FFFF and 0001 give 0001.
- R4: When the summed region holds an odd number of bytes, its last byte is added as {byte, 8'h00}.
- R5: Bytes at frame positions below `cfg_start_ofs` are excluded from the sum. The first byte of the frame is position 0, and an offset of 0 sums the whole frame.
- R6: If `cfg_start_ofs` is greater than or equal to the frame length, the result is 0.
- R7: `csum_done` is high for exactly the one cycle after an accepted end-of-frame byte, and is low in every other cycle.
- R8: `csum_out` changes only on a cycle where `csum_done` is high, and otherwise holds the last result.
- R9: A start-of-frame byte always begins a new sum at position 0, even if the previous frame never saw its end-of-frame byte.
- R10: Cycles with `in_valid` low have no effect on the sum or on byte positions.
- R11: A valid byte arriving while no frame is open and without `in_sof` is ignored. It produces no done strobe, even when `in_eof` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_ofs | input | OFS_W | Frame byte position where summing begins; held constant during a frame |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | in_data carries a byte this cycle |
| in_sof | input | 1 | Byte is the first byte of a frame |
| in_eof | input | 1 | Byte is the last byte of a frame |
| csum_out | output | 16 | Ones-complement sum of the last completed frame |
| csum_done | output | 1 | One-cycle strobe: csum_out holds a new result |

## Verification
A wrong internal position count or a lost high-byte flag does not show at the ports until the end of the frame. It then appears as a wrong `csum_out` on the single cycle of `csum_done`, one cycle after end-of-frame. For this reason every frame is checked at exactly that cycle against a model sum, using several offsets, odd and even lengths, and gaps between bytes. A stuck frame-open flag shows as a missing done strobe or a spurious one. The strobe is therefore checked in every cycle, including around stray bytes and aborted frames.

// File: rtl/rx_ocsum.sv
module rx_ocsum #(
  parameter int OFS_W = 11,
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] cfg_start_ofs,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic [15:0]      csum_out,
  output logic             csum_done
);

  logic [POS_W-1:0] pos_q;
  logic             in_frame_q;
  logic             hi_vld_q;
  logic [7:0]       hi_q;
  logic [15:0]      sum_q;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  wire              accept  = in_valid && (in_sof || in_frame_q);
  wire [POS_W-1:0]  cur_pos = in_sof ? '0 : pos_q;
  wire              take    = cur_pos >= POS_W'(cfg_start_ofs);
  wire              cur_hi  = !in_sof && hi_vld_q;
  wire [15:0]       base    = in_sof ? 16'd0 : sum_q;
  wire [15:0]       word    = cur_hi ? {hi_q, in_data} : {in_data, 8'h00};
  wire              add_now = take && (cur_hi || in_eof);
  wire [15:0]       nxt_sum = add_now ? oc_add(base, word) : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
      hi_vld_q   <= 1'b0;
      hi_q       <= 8'h00;
      sum_q      <= 16'd0;
      csum_out   <= 16'd0;
      csum_done  <= 1'b0;
    end else begin
      csum_done <= accept && in_eof;
      if (accept) begin
        sum_q      <= nxt_sum;
        pos_q      <= (&cur_pos) ? cur_pos : cur_pos + 1'b1;
        hi_vld_q   <= take && !cur_hi && !in_eof;
        in_frame_q <= !in_eof;
        if (take && !cur_hi) hi_q <= in_data;
        if (in_eof) csum_out <= nxt_sum;
      end
    end
  end

endmodule

// File: rtl/rx_ocsum_chk.sv
module rx_ocsum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sof,
  input logic        in_eof,
  input logic        in_frame_q,
  input logic [15:0] csum_out,
  input logic        csum_done
);

  logic seen_q;
  always_ff @(posedge clk) seen_q <= rst_n;

  wire fin = in_valid && in_eof && (in_sof || in_frame_q);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (csum_out == 16'd0 && !csum_done));

  a_r7_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> csum_done);

  a_r7_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> !csum_done);

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !csum_done) |-> $stable(csum_out));

endmodule

bind rx_ocsum rx_ocsum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .in_frame_q(in_frame_q), .csum_out(csum_out),
  .csum_done(csum_done)
);

// File: tb/test_rx_ocsum.sv
`timescale 1ns/1ps
module test_rx_ocsum;
  localparam int OFS_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OFS_W-1:0] cfg_start_ofs = '0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [15:0] csum_out;
  logic csum_done;

  int n_chk = 0, n_err = 0;
  logic [7:0] fb [0:255];
  logic [15:0] last_res = 16'd0;

  always #2.5 clk = ~clk;

  rx_ocsum #(.OFS_W(OFS_W), .POS_W(16)) i_rx_ocsum (
    .clk(clk), .rst_n(rst_n), .cfg_start_ofs(cfg_start_ofs),
    .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .csum_out(csum_out), .csum_done(csum_done)
  );

  function automatic logic [15:0] ocadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] model(input int len, input int ofs);
    logic [15:0] s;
    s = 16'd0;
    for (int i = ofs; i < len; i += 2) begin
      if (i + 1 < len) s = ocadd(s, {fb[i], fb[i+1]});
      else             s = ocadd(s, {fb[i], 8'h00});
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives bytes from fb; gaps inserted with probability gap_pct; checks done each cycle
  task automatic send(input int len, input int ofs, input int gap_pct, input bit do_eof, input string req);
    cfg_start_ofs = OFS_W'(ofs);
    for (int i = 0; i < len; i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        check({req, "/R7 gap"}, {31'd0, csum_done}, 32'd0);
        check({req, "/R8 hold"}, {16'd0, csum_out}, {16'd0, last_res});
      end
      in_valid = 1'b1; in_data = fb[i];
      in_sof = (i == 0); in_eof = do_eof && (i == len - 1);
      @(negedge clk);
      if (do_eof && i == len - 1) begin
        last_res = model(len, ofs);
        check({req, "/R7 done"}, {31'd0, csum_done}, 32'd1);
        check(req, {16'd0, csum_out}, {16'd0, last_res});
      end else begin
        check({req, "/R7 mid"}, {31'd0, csum_done}, 32'd0);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 csum in reset", {16'd0, csum_out}, 32'd0);
    check("R1 done in reset", {31'd0, csum_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 csum after reset", {16'd0, csum_out}, 32'd0);
    check("R1 done after reset", {31'd0, csum_done}, 32'd0);

    // R2: 12 34 56 78 -> 1234 + 5678 = 68AC
    fb[0]=8'h12; fb[1]=8'h34; fb[2]=8'h56; fb[3]=8'h78;
    send(4, 0, 0, 1'b1, "R2 pairing");
    check("R2 literal", {16'd0, csum_out}, 32'h68AC);

    // R3: FFFF + FFFF + 0001 -> 0001
    fb[0]=8'hFF; fb[1]=8'hFF; fb[2]=8'hFF; fb[3]=8'hFF; fb[4]=8'h00; fb[5]=8'h01;
    send(6, 0, 0, 1'b1, "R3 carry");
    check("R3 literal", {16'd0, csum_out}, 32'h0001);

    // R4: 12 34 56 -> 1234 + 5600 = 6834
    fb[0]=8'h12; fb[1]=8'h34; fb[2]=8'h56;
    send(3, 0, 0, 1'b1, "R4 odd pad");
    check("R4 literal", {16'd0, csum_out}, 32'h6834);

    // R5: offset 1 on same bytes -> 3456
    send(3, 1, 0, 1'b1, "R5 offset");
    check("R5 literal", {16'd0, csum_out}, 32'h3456);

    // R6: offset beyond length -> 0
    send(3, 10, 0, 1'b1, "R6 past end");
    check("R6 literal", {16'd0, csum_out}, 32'h0000);

    // R9: aborted frame then new SOF
    for (int i = 0; i < 5; i++) fb[i] = 8'hA0 + 8'(i);
    send(5, 0, 0, 1'b0, "R9 abort");
    fb[0]=8'h01; fb[1]=8'h02;
    send(2, 0, 0, 1'b1, "R9 restart");
    check("R9 literal", {16'd0, csum_out}, 32'h0102);

    // R11: stray bytes with no open frame, one carrying eof
    in_valid = 1'b1; in_sof = 1'b0; in_data = 8'h77; in_eof = 1'b0;
    @(negedge clk);
    in_eof = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    check("R11 no done", {31'd0, csum_done}, 32'd0);
    check("R11 csum held", {16'd0, csum_out}, {16'd0, last_res});

    // R10 with R2..R5: random frames with gaps
    for (int f = 0; f < 60; f++) begin
      int len, ofs;
      len = 1 + int'($urandom_range(63));
      ofs = int'($urandom_range(20));
      for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
      send(len, ofs, (f % 3 == 0) ? 0 : 30, 1'b1, "R10 random frame");
    end

    // back-to-back single-byte frames: R7
    fb[0] = 8'h9C;
    send(1, 0, 0, 1'b1, "R7 single A");
    send(1, 0, 0, 1'b1, "R7 single B");
    check("R7 single literal", {16'd0, csum_out}, 32'h9C00);

    repeat (3) @(negedge clk);
    check("R7 idle", {31'd0, csum_done}, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule